// File: doc/BRIEF.md
# Serial Configuration Port Receiver

This block takes converter configuration from a host over a small write-only serial port. The host raises an enable, shifts in one 8-bit frame MSB first on a slow port clock, then drops the enable. The frame goes into a configuration register only if exactly eight capture edges arrived while the enable was high. The register feeds the rest of the converter. Bit 7 selects the 10 V range, bit 6 selects the bipolar range, and bits 5..0 carry further mode bits.

The serial port is live only in serial mode (mode input equal to 3) with software configuration selected (hardware-select low). In the parallel modes (0, 1, 2) these pins belong to the data bus and the port ignores them. The block also picks the range source. With software configuration in serial mode, the effective range comes from the register. In every other case it comes straight from the two range pins. A clock-invert input picks the capture edge. The port clock, enable and data are brought into the system clock domain through a two-flop synchroniser, and edges are detected there. The block has no valid/ready handshake: the serial side has no back-pressure, and the register output is a plain level that holds between commits.

Top module: `cfg_serial_rx`

## Requirements
- R1: After reset the configuration register is 0x00 (unipolar, narrow range). In serial mode with software configuration, both effective range outputs are then 0.
- R2: A frame of exactly 8 capture edges, shifted MSB first, is copied to the configuration register when the enable deasserts. The register changes no later than 3 system clocks after the enable falls.
- R3: A frame with any count of capture edges other than 8 (for example 7 or 9) leaves the configuration register unchanged.
- R4: With clock-invert at 0, data is captured on the rising edge of the port clock. With clock-invert at 1, it is captured on the falling edge.
- R5: When the mode input is not 3, serial activity has no effect on the configuration register.
- R6: When hardware-select is 1, serial activity has no effect on the configuration register.
- R7: In serial mode with hardware-select at 1, the effective 10 V and bipolar outputs equal the range pins.
- R8: In serial mode with hardware-select at 0, the effective 10 V output equals register bit 7 and the effective bipolar output equals register bit 6. The range pins are ignored.
- R9: In modes 0, 1 and 2, the effective range outputs equal the range pins.
- R10: The configuration register changes only at a commit and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Interface mode; 3 is serial mode |
| hw_sel | input | 1 | 1: range from pins; 0: range from serial register |
| port_en | input | 1 | Serial port enable, active high, frames a write |
| port_clk | input | 1 | Serial port clock (asynchronous to clk) |
| port_data | input | 1 | Serial data, MSB first |
| clk_inv | input | 1 | 0: capture on rising port_clk; 1: on falling |
| pin_ten | input | 1 | Direct 10 V range select pin |
| pin_bip | input | 1 | Direct bipolar range select pin |
| cfg_word | output | 8 | Configuration register |
| eff_ten | output | 1 | Effective 10 V range select |
| eff_bip | output | 1 | Effective bipolar range select |

## Verification
Each serial input passes through two synchroniser flops and one edge-detect flop. A shift therefore lands on the third system clock after the port clock toggles, and a commit lands on the third clock after the enable falls. The effective range outputs are combinational and follow the pins or the register within the same cycle. The bench holds every port-clock and enable level for at least 4 system clocks, changes data away from the capture edge, and samples the register 8 clocks after the enable drops. It samples the range outputs one time step after changing the pins, always on the falling clock edge.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;
  localparam logic [1:0] SERIAL_MODE = 2'd3;
  localparam int         CFG_W       = 8;
  localparam int         TEN_POS     = 7;
  localparam int         BIP_POS     = 6;
  localparam logic [CFG_W-1:0] CFG_RESET = '0;

  typedef struct packed {
    logic       ten;
    logic       bip;
    logic [5:0] aux;
  } cfg_t;
endpackage

// File: rtl/cfg_rx_sync.sv
module cfg_rx_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_rx_edge.sv
module cfg_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic en_s,
  input  logic inv,
  output logic cap_pulse,
  output logic en_fall
);
  logic sclk_d;
  logic en_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      en_d   <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      en_d   <= en_s;
    end
  end

  always_comb begin
    if (inv) cap_pulse = sclk_d & ~sclk_s;
    else     cap_pulse = ~sclk_d & sclk_s;
  end

  assign en_fall = en_d & ~en_s;
endmodule

// File: rtl/cfg_rx_shift.sv
module cfg_rx_shift #(
  parameter int FRAME_W = 8,
  parameter int CNT_W   = $clog2(FRAME_W + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               serial_sel,
  input  logic               en_s,
  input  logic               d_s,
  input  logic               cap_pulse,
  input  logic               en_fall,
  output logic [FRAME_W-1:0] cfg_q,
  output logic               commit,
  output logic [CNT_W-1:0]   bit_cnt
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg;

  assign commit = en_fall && serial_sel && (bit_cnt == CNT_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (!serial_sel || !en_s) begin
      bit_cnt <= '0;
    end else if (cap_pulse) begin
      shreg <= {shreg[FRAME_W-2:0], d_s};
      if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (commit) cfg_q <= shreg;
  end
endmodule

// File: rtl/cfg_rx_src.sv
module cfg_rx_src
  import cfg_rx_pkg::*;
(
  input  logic             serial_sel,
  input  logic [CFG_W-1:0] cfg_q,
  input  logic             pin_ten,
  input  logic             pin_bip,
  output logic             eff_ten,
  output logic             eff_bip
);
  cfg_t cfg_view;
  assign cfg_view = cfg_t'(cfg_q);

  always_comb begin
    if (serial_sel) begin
      eff_ten = cfg_view.ten;
      eff_bip = cfg_view.bip;
    end else begin
      eff_ten = pin_ten;
      eff_bip = pin_bip;
    end
  end
endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx
  import cfg_rx_pkg::*;
#(
  parameter int FRAME_W     = CFG_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_sel,
  input  logic               hw_sel,
  input  logic               port_en,
  input  logic               port_clk,
  input  logic               port_data,
  input  logic               clk_inv,
  input  logic               pin_ten,
  input  logic               pin_bip,
  output logic [FRAME_W-1:0] cfg_word,
  output logic               eff_ten,
  output logic               eff_bip
);
  localparam int CNT_W = $clog2(FRAME_W + 2);

  logic [2:0]       raw_in;
  logic [2:0]       sync_out;
  logic             sclk_s, en_s, d_s;
  logic             cap_w, en_fall_w, commit_w;
  logic             serial_sel;
  logic [CNT_W-1:0] bit_cnt_w;

  assign serial_sel = (mode_sel == SERIAL_MODE) && !hw_sel;
  assign raw_in     = {port_clk, port_en, port_data};
  assign {sclk_s, en_s, d_s} = sync_out;

  cfg_rx_sync #(.STAGES(SYNC_STAGES), .W(3)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_async(raw_in), .d_sync(sync_out)
  );

  cfg_rx_edge edge_i (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .en_s(en_s), .inv(clk_inv),
    .cap_pulse(cap_w), .en_fall(en_fall_w)
  );

  cfg_rx_shift #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .serial_sel(serial_sel), .en_s(en_s), .d_s(d_s),
    .cap_pulse(cap_w), .en_fall(en_fall_w), .cfg_q(cfg_word), .commit(commit_w),
    .bit_cnt(bit_cnt_w)
  );

  cfg_rx_src src_i (
    .serial_sel(serial_sel), .cfg_q(cfg_word[CFG_W-1:0]), .pin_ten(pin_ten),
    .pin_bip(pin_bip), .eff_ten(eff_ten), .eff_bip(eff_bip)
  );
endmodule

// File: rtl/cfg_serial_rx_chk.sv
module cfg_serial_rx_chk #(
  parameter int FRAME_W = 8,
  parameter int CNT_W   = $clog2(FRAME_W + 2)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         mode_sel,
  input logic               hw_sel,
  input logic [FRAME_W-1:0] cfg_word,
  input logic               commit,
  input logic [CNT_W-1:0]   bit_cnt,
  input logic               eff_ten,
  input logic               eff_bip,
  input logic               pin_ten,
  input logic               pin_bip
);
  // R1
  reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfg_word == '0));

  // R3
  full_frame_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (bit_cnt == CNT_W'(FRAME_W)));

  // R5
  no_write_other_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 2'd3) |=> $stable(cfg_word));

  // R6
  no_write_hw_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_sel |=> $stable(cfg_word));

  // R10
  hold_between_commits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(cfg_word));

  // R9
  parallel_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 2'd3) |-> (eff_ten == pin_ten && eff_bip == pin_bip));
endmodule

bind cfg_serial_rx cfg_serial_rx_chk #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .hw_sel(hw_sel),
  .cfg_word(cfg_word), .commit(commit_w), .bit_cnt(bit_cnt_w),
  .eff_ten(eff_ten), .eff_bip(eff_bip), .pin_ten(pin_ten), .pin_bip(pin_bip)
);

// File: tb/cfg_serial_rx_tb_top.sv
module cfg_serial_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'd3;
  logic       hw_sel = 1'b0;
  logic       port_en = 1'b0;
  logic       port_clk = 1'b0;
  logic       port_data = 1'b0;
  logic       clk_inv = 1'b0;
  logic       pin_ten = 1'b0;
  logic       pin_bip = 1'b0;
  logic [7:0] cfg_word;
  logic       eff_ten, eff_bip;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [7:0] model;

  always #2 clk = ~clk;

  cfg_serial_rx dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .hw_sel(hw_sel),
    .port_en(port_en), .port_clk(port_clk), .port_data(port_data),
    .clk_inv(clk_inv), .pin_ten(pin_ten), .pin_bip(pin_bip),
    .cfg_word(cfg_word), .eff_ten(eff_ten), .eff_bip(eff_bip)
  );

  function automatic logic [7:0] exp_cfg(logic [7:0] cur, logic [7:0] frame,
                                         int n, logic [1:0] m, logic h);
    if (m == 2'd3 && !h && n == 8) return frame;
    return cur;
  endfunction

  function automatic logic [1:0] exp_eff(logic [7:0] c, logic [1:0] m, logic h,
                                         logic pt, logic pb);
    if (m == 2'd3 && !h) return {c[7], c[6]};
    return {pt, pb};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  // Shift n bits of frame MSB first; bits past 8 repeat bit 0.
  task automatic send(logic [7:0] frame, int n, logic inv);
    clk_inv  = inv;
    port_clk = inv;
    wait_clk(8);
    port_en = 1'b1;
    wait_clk(8);
    for (int i = 0; i < n; i++) begin
      port_data = (i < 8) ? frame[7-i] : frame[0];
      wait_clk(4);
      port_clk = ~inv;            // capture edge
      wait_clk(4);
      port_data = ~port_data;     // data moves away from capture edge
      wait_clk(4);
      port_clk = inv;             // non-capture edge
      wait_clk(4);
    end
    wait_clk(8);
    port_en = 1'b0;
    wait_clk(8);
  endtask

  task automatic run_frame(string req, logic [7:0] frame, int n, logic inv);
    send(frame, n, inv);
    model = exp_cfg(model, frame, n, mode_sel, hw_sel);
    check(req, {24'd0, cfg_word}, {24'd0, model});
  endtask

  task automatic check_eff(string req);
    #1;
    check(req, {30'd0, eff_ten, eff_bip},
          {30'd0, exp_eff(model, mode_sel, hw_sel, pin_ten, pin_bip)});
  endtask

  initial begin
    model = 8'h00;
    void'($urandom(32'h5eed_1234));
    wait_clk(3);
    // R1 reset state
    check("R1", {24'd0, cfg_word}, 32'h0);
    rst_n = 1'b1;
    wait_clk(2);
    check("R1", {24'd0, cfg_word}, 32'h0);
    pin_ten = 1'b1; pin_bip = 1'b1;
    check_eff("R1");

    // R2 / R4 directed frames, both capture polarities
    run_frame("R2", 8'hA5, 8, 1'b0);
    run_frame("R4", 8'h3C, 8, 1'b1);
    run_frame("R4", 8'hC3, 8, 1'b0);
    // R8 register drives range, pins ignored
    pin_ten = 1'b0; pin_bip = 1'b1;
    check_eff("R8");
    // R3 short and long frames
    run_frame("R3", 8'h5A, 7, 1'b0);
    run_frame("R3", 8'h0F, 9, 1'b1);
    // R6 hardware select blocks writes; R7 pins drive range
    hw_sel = 1'b1;
    run_frame("R6", 8'hFF, 8, 1'b0);
    pin_ten = 1'b1; pin_bip = 1'b0;
    check_eff("R7");
    hw_sel = 1'b0;
    // R5 parallel modes block writes; R9 pins drive range
    for (int m = 0; m < 3; m++) begin
      mode_sel = 2'(m);
      run_frame("R5", 8'h81 + 8'(m), 8, 1'(m));
      pin_ten = 1'(m); pin_bip = ~1'(m);
      check_eff("R9");
    end
    mode_sel = 2'd3;
    // R10 hold over idle time
    wait_clk(50);
    check("R10", {24'd0, cfg_word}, {24'd0, model});

    // Random mix
    for (int k = 0; k < 30; k++) begin
      logic [7:0] fr;
      int n;
      fr = 8'($urandom);
      n = 7 + ($urandom % 3);
      if ($urandom % 2) n = 8;
      mode_sel = ($urandom % 4 == 0) ? 2'($urandom % 3) : 2'd3;
      hw_sel = ($urandom % 4 == 0);
      run_frame("R2", fr, n, 1'($urandom));
      pin_ten = 1'($urandom); pin_bip = 1'($urandom);
      check_eff("R8");
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule